// File: doc/BRIEF.md
# Delayed Pulse Generator (Two Cascaded One-Shots)

This block emits a pulse of programmable width a programmable time after each falling edge of a trigger input. It does this with two counter-based one-shots in series. The first one-shot is edge-triggered and retriggerable. It starts a delay pulse lasting `delayCycles` clock periods. The second one-shot fires on the trailing edge of that delay pulse and produces the final pulse, lasting `widthCycles` clock periods.

All state changes on the falling edge of `clk`. The trigger is sampled on the same edge, so the trigger must be held across a falling clock edge to be seen. The two length values are meant to be static: tied off or set from switches. A trigger falling edge is recognised when the trigger is sampled low at one falling clock edge and was sampled high at the previous one. A typical use is to place a strobe a fixed time after an external event, for example delaying a sampling pulse after a slow clock's falling edge.

Top module: `delayed_pulse_gen`

## Requirements
- R1: Driving `rstN` low clears both counters at once, without waiting for a clock edge, so `delayPulse` and `outPulse` go low immediately. The stored trigger history is also cleared.
- R2: All state, and therefore both outputs, changes only on falling edges of `clk`, except for the asynchronous clear in R1.
- R3: If `trig` is sampled low at a falling clock edge after being sampled high at the previous falling edge, the delay counter loads `delayCycles` at that edge. `delayPulse` is then high for exactly `delayCycles` clock periods, starting at that edge.
- R4: A trigger held high or held low loads nothing. A rising trigger edge also loads nothing. Only a high-to-low change between two consecutive falling-edge samples starts the delay.
- R5: A new trigger falling edge while `delayPulse` is high reloads the delay counter with `delayCycles`, which extends the delay pulse.
- R6: With `delayCycles` equal to 0, a trigger falling edge produces neither a delay pulse nor an output pulse.
- R7: The output counter loads `widthCycles` at the first falling clock edge that samples `delayPulse` low after a sample where it was high. This is one clock period after `delayPulse` falls. `outPulse` is then high for exactly `widthCycles` clock periods.
- R8: With `widthCycles` equal to 0, no output pulse appears.
- R9: When the trigger period exceeds `delayCycles + widthCycles + 2` clock periods and both values are nonzero, exactly one `outPulse` appears per trigger falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the falling edge is the active edge |
| rstN | input | 1 | Asynchronous active-low clear |
| trig | input | 1 | Trigger; its falling edges start the delay |
| delayCycles | input | CNT_W | Delay length in clock periods (static) |
| widthCycles | input | CNT_W | Output pulse width in clock periods (static) |
| delayPulse | output | 1 | High while the delay is running |
| outPulse | output | 1 | Final delayed pulse |

## Verification
The bench builds the block with the default counter width of 4. With that width, every length from 0 to the maximum of 15 is reachable, and random draws can hit both ends in a short run. Directed patterns place a retrigger four cycles into a delay of 8, so the expected extended length of 12 is exact. A reset is asserted between clock edges in the middle of a pulse to show the clear is asynchronous. A long random phase with varied hold lengths and occasional zero lengths is compared cycle by cycle against a model built from the requirements.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  // Strobes from the edge-detect control to the counter datapath
  typedef struct packed {
    logic loadDelay;
    logic loadWidth;
  } dpgStrobe_t;
endpackage

// File: rtl/dpg_control.sv
module dpg_control
  import dpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trig,
  input  logic       delayPulse,
  output dpgStrobe_t strobes
);
  logic trigSeen;
  logic dlySeen;

  // Sample histories on the falling clock edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      trigSeen <= 1'b0;
      dlySeen  <= 1'b0;
    end else begin
      trigSeen <= trig;
      dlySeen  <= delayPulse;
    end
  end

  // A high-to-low change between consecutive samples fires a stage
  always_comb begin
    strobes.loadDelay = trigSeen & ~trig;
    strobes.loadWidth = dlySeen & ~delayPulse;
  end
endmodule

// File: rtl/dpg_datapath.sv
module dpg_datapath
  import dpg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpgStrobe_t       strobes,
  input  logic [CNT_W-1:0] delayCycles,
  input  logic [CNT_W-1:0] widthCycles,
  output logic [CNT_W-1:0] delayCount,
  output logic [CNT_W-1:0] widthCount,
  output logic             delayPulse,
  output logic             outPulse
);
  localparam int NUM_STAGES = 2;

  logic [CNT_W-1:0] loadVal [NUM_STAGES];
  logic             loadEn  [NUM_STAGES];
  logic [CNT_W-1:0] count   [NUM_STAGES];
  logic             busy    [NUM_STAGES];

  assign loadVal[0] = delayCycles;
  assign loadVal[1] = widthCycles;
  assign loadEn[0]  = strobes.loadDelay;
  assign loadEn[1]  = strobes.loadWidth;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN)          count[s] <= '0;
      else if (loadEn[s]) count[s] <= loadVal[s];
      else if (busy[s])   count[s] <= count[s] - 1'b1;
    end
    assign busy[s] = |count[s];
  end

  assign delayCount = count[0];
  assign widthCount = count[1];
  assign delayPulse = busy[0];
  assign outPulse   = busy[1];
endmodule

// File: rtl/delayed_pulse_gen.sv
module delayed_pulse_gen
  import dpg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trig,
  input  logic [CNT_W-1:0] delayCycles,
  input  logic [CNT_W-1:0] widthCycles,
  output logic             delayPulse,
  output logic             outPulse
);
  dpgStrobe_t       strobes;
  logic [CNT_W-1:0] dlyCount;
  logic [CNT_W-1:0] widCount;

  dpg_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .trig       (trig),
    .delayPulse (delayPulse),
    .strobes    (strobes)
  );

  dpg_datapath #(.CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .delayCycles (delayCycles),
    .widthCycles (widthCycles),
    .delayCount  (dlyCount),
    .widthCount  (widCount),
    .delayPulse  (delayPulse),
    .outPulse    (outPulse)
  );
endmodule

// File: rtl/delayed_pulse_gen_chk.sv
module delayed_pulse_gen_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             trig,
  input logic [CNT_W-1:0] delayCycles,
  input logic [CNT_W-1:0] widthCycles,
  input logic [CNT_W-1:0] dlyCount,
  input logic             delayPulse,
  input logic             outPulse
);
  logic trigPrev;
  logic dlyPrev;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
      dlyPrev  <= 1'b0;
    end else begin
      trigPrev <= trig;
      dlyPrev  <= delayPulse;
    end
  end

  always @(negedge clk) begin
    if (!rstN) AST_RESET_QUIET: assert (!delayPulse && !outPulse); // R1
  end

  AST_DELAY_START: assert property (@(negedge clk) disable iff (!rstN)
    (trigPrev && !trig && delayCycles != '0) |=> delayPulse); // R3
  AST_DELAY_DOWN: assert property (@(negedge clk) disable iff (!rstN)
    (dlyCount != '0 && !(trigPrev && !trig)) |=> (dlyCount == $past(dlyCount) - 1'b1)); // R3
  AST_LEVEL_QUIET: assert property (@(negedge clk) disable iff (!rstN)
    (!delayPulse && !(trigPrev && !trig)) |=> !delayPulse); // R4
  AST_RETRIG_LOAD: assert property (@(negedge clk) disable iff (!rstN)
    (delayPulse && trigPrev && !trig) |=> (dlyCount == $past(delayCycles))); // R5
  AST_ZERO_DELAY: assert property (@(negedge clk) disable iff (!rstN)
    (delayCycles == '0 && !delayPulse) |=> !delayPulse); // R6
  AST_OUT_START: assert property (@(negedge clk) disable iff (!rstN)
    (dlyPrev && !delayPulse && widthCycles != '0) |=> outPulse); // R7
  AST_OUT_QUIET: assert property (@(negedge clk) disable iff (!rstN)
    (!outPulse && !(dlyPrev && !delayPulse)) |=> !outPulse); // R8
endmodule

bind delayed_pulse_gen delayed_pulse_gen_chk #(.CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .trig        (trig),
  .delayCycles (delayCycles),
  .widthCycles (widthCycles),
  .dlyCount    (dlyCount),
  .delayPulse  (delayPulse),
  .outPulse    (outPulse)
);

// File: tb/tb_delayed_pulse_gen.sv
`timescale 1ns/1ps
module tb_delayed_pulse_gen;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             trig = 1'b0;
  logic [CNT_W-1:0] delayCycles = '0;
  logic [CNT_W-1:0] widthCycles = '0;
  logic             delayPulse;
  logic             outPulse;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 0;
  bit done = 0;

  always #5 clk = ~clk;

  delayed_pulse_gen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .trig(trig),
    .delayCycles(delayCycles), .widthCycles(widthCycles),
    .delayPulse(delayPulse), .outPulse(outPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model of the requirements (R3, R5, R7): next count after one active edge
  function automatic int nextCnt(input int cnt, input bit fire, input int loadVal);
    if (fire) return loadVal;
    if (cnt != 0) return cnt - 1;
    return 0;
  endfunction

  int  mC1 = 0, mC2 = 0;
  bit  mT = 0, mD = 0;
  always @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      mC1 = 0; mC2 = 0; mT = 0; mD = 0;
    end else begin
      bit f1, f2;
      f1 = mT && !trig;
      f2 = mD && (mC1 == 0);
      mT = trig;
      mD = (mC1 != 0);
      mC1 = nextCnt(mC1, f1, int'(delayCycles));
      mC2 = nextCnt(mC2, f2, int'(widthCycles));
    end
  end

  // R2: outputs compared at the rising edge, half a period after the active edge
  always @(posedge clk) begin
    if (cmpOn) begin
      chk("R2 model delayPulse", int'(delayPulse), int'(mC1 != 0));
      chk("R2 model outPulse", int'(outPulse), int'(mC2 != 0));
    end
  end

  task automatic shape(input int span, input int hiAt, input int loAt,
                       output int dStart, output int dLen, output int oStart, output int oLen);
    dStart = -1; dLen = 0; oStart = -1; oLen = 0;
    for (int k = 1; k <= span; k++) begin
      @(posedge clk);
      if (delayPulse) begin if (dStart < 0) dStart = k; dLen++; end
      if (outPulse)   begin if (oStart < 0) oStart = k; oLen++; end
      if (k == hiAt) trig <= 1'b1;
      if (k == loAt) trig <= 1'b0;
    end
  endtask

  task automatic fallNow();
    @(posedge clk); trig <= 1'b1;
    @(posedge clk); trig <= 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ds, dl, os, ol, falls, rises;
    bit lastT, lastO;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    // R1: reset state
    chk("R1 reset delayPulse", int'(delayPulse), 0);
    chk("R1 reset outPulse", int'(outPulse), 0);
    @(posedge clk); rstN <= 1'b1;
    cmpOn = 1;

    // R3 and R7: basic delay then width
    delayCycles = 4'd5; widthCycles = 4'd3;
    fallNow();
    shape(30, -1, -1, ds, dl, os, ol);
    chk("R3 delay start", ds, 1);
    chk("R3 delay length", dl, 5);
    chk("R7 out start", os, 7);
    chk("R7 out length", ol, 3);

    // R3 and R7: maximum values
    delayCycles = 4'd15; widthCycles = 4'd15;
    fallNow();
    shape(40, -1, -1, ds, dl, os, ol);
    chk("R3 delay length max", dl, 15);
    chk("R7 out start max", os, 17);
    chk("R7 out length max", ol, 15);

    // R4: rising edge and held high give nothing; held low after one fall gives one pulse
    delayCycles = 4'd4; widthCycles = 4'd2;
    @(posedge clk); trig <= 1'b1;
    shape(30, -1, -1, ds, dl, os, ol);
    chk("R4 held high delay", dl, 0);
    chk("R4 held high out", ol, 0);
    @(posedge clk); trig <= 1'b0;
    shape(40, -1, -1, ds, dl, os, ol);
    chk("R4 single fall delay", dl, 4);
    chk("R4 held low out count", ol, 2);

    // R5: retrigger at cycle 4 of an 8-cycle delay extends it to 12
    delayCycles = 4'd8; widthCycles = 4'd2;
    fallNow();
    shape(30, 3, 4, ds, dl, os, ol);
    chk("R5 extended delay", dl, 12);
    chk("R5 out start", os, 14);
    chk("R5 out length", ol, 2);

    // R6: zero delay
    delayCycles = 4'd0; widthCycles = 4'd4;
    fallNow();
    shape(20, -1, -1, ds, dl, os, ol);
    chk("R6 zero delay pulse", dl, 0);
    chk("R6 zero delay out", ol, 0);

    // R8: zero width
    delayCycles = 4'd3; widthCycles = 4'd0;
    fallNow();
    shape(20, -1, -1, ds, dl, os, ol);
    chk("R8 zero width delay", dl, 3);
    chk("R8 zero width out", ol, 0);

    // R1: asynchronous clear between clock edges in the middle of a pulse
    delayCycles = 4'd10; widthCycles = 4'd2;
    fallNow();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b0;
    #1;
    chk("R1 async clear delayPulse", int'(delayPulse), 0);
    chk("R1 async clear outPulse", int'(outPulse), 0);
    @(posedge clk); rstN <= 1'b1;
    shape(20, -1, -1, ds, dl, os, ol);
    chk("R1 no resume delay", dl, 0);
    chk("R1 no resume out", ol, 0);

    // Random phase, checked every cycle by the model (R2)
    for (int round = 0; round < 8; round++) begin
      delayCycles = CNT_W'($urandom_range(0, 15));
      widthCycles = CNT_W'($urandom_range(0, 15));
      if (round == 2) delayCycles = '0;
      if (round == 3) widthCycles = '0;
      for (int n = 0; n < 150; n++) begin
        @(posedge clk); trig <= ~trig;
        repeat ($urandom_range(0, 6)) @(posedge clk);
      end
    end

    // R9: trigger period longer than delay + width + 2
    @(posedge clk); trig <= 1'b0;
    delayCycles = 4'd5; widthCycles = 4'd3;
    repeat (30) @(posedge clk);
    falls = 0; rises = 0; lastT = trig; lastO = outPulse;
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 12; k++) begin
        @(posedge clk);
        if (outPulse && !lastO) rises++;
        lastO = outPulse;
        trig <= (k < 6);
        if (lastT && !(k < 6)) falls++;
        lastT = (k < 6);
      end
    end
    trig <= 1'b0;
    repeat (30) begin
      @(posedge clk);
      if (outPulse && !lastO) rises++;
      lastO = outPulse;
    end
    chk("R9 trigger falls", falls, 20);
    chk("R9 one out per fall", rises, falls);

    cmpOn = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule